// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block connects a simple synchronous request port to an 8K x 8 asynchronous static RAM. A requester offers one access at a time with a valid/ready handshake: a read/write flag, a 13-bit word address and, for writes, one data byte. The controller then drives the memory's address, a pair of chip selects of opposite polarity, the write strobe and the output enable. It also drives a data bus split into an output byte, an input byte and a driver enable. When the access has finished, the controller returns a one-cycle completion pulse and, for reads, the captured byte.

The memory has no clock, so every phase of an access is a run of whole clock cycles counted down by a timer. Each run length is computed at elaboration from a clock-period parameter and the memory's nanosecond minimums, rounded up. A read holds the chip selected with output enable low for one window and samples the bus on the last cycle of it. A write has three phases: setup, write-strobe pulse and recovery. The bus driver is on only while the memory is guaranteed not to be driving the bus.

After reset, both chip selects are inactive so the memory sits in standby. Once the first access has run, the memory stays selected between accesses with write enable and output enable both high, so its pins float.

Top module: `sram_timing_ctrl`

## Requirements
- R1: While reset is applied and in the cycle after it, mem_ce_n is 1, mem_ce is 0, mem_we_n and mem_oe_n are 1, mem_dq_oe and rsp_done are 0, and req_ready is 1.
- R2: req_ready is 1 only when no access is in progress. A request is taken in a cycle where req_valid and req_ready are both 1, and req_ready is 0 from the next cycle until the access completes.
- R3: A read keeps the chip selected (mem_ce_n=0, mem_ce=1), with mem_we_n=1 and mem_oe_n=0, for ceil(max(500 ns, 200 ns)/period) cycles. It samples mem_dq_in at the end of the last of those cycles. rsp_done is then 1 for exactly one cycle, with the sampled byte on rsp_rdata.
- R4: In a write, the address and chip select are present for at least ceil(max(100 ns, 40 ns)/period) cycles before mem_we_n falls.
- R5: mem_we_n stays low for at least 150 ns. The driven write byte is stable for at least 100 ns before mem_we_n rises. The address is stable while mem_we_n is low and for at least 250 ns before it rises.
- R6: Every access lasts ceil(500 ns/period) cycles from the cycle after acceptance, and rsp_done appears in the cycle that follows. In a write, the address stays held for at least 50 ns after mem_we_n rises.
- R7: mem_dq_oe is never 1 while the chip is selected with mem_oe_n=0. It rises only while mem_we_n is low, after mem_oe_n has been high for at least 40 ns. It falls exactly one cycle after mem_we_n rises.
- R8: Between accesses, once one access has run, the chip stays selected with mem_we_n=1, mem_oe_n=1 and mem_dq_oe=0.
- R9: A read returns the byte most recently written to the same address; an address never written reads as 0 in the memory model.
- R10: A request raised and withdrawn while an access is in progress is ignored. The address and strobes of the running access do not change, and no access follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_rdata | output | 8 | Byte returned by the last read |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 13 | Memory address |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | 8 | Byte read from the data bus |

## Verification
The bench runs a random mix of reads and writes over a small address window, so reads often hit freshly written bytes. Directed cases cover the lowest and highest address, back-to-back writes to one address, a read of a never-written word, and the first access coming out of standby. The bus model returns a garbage byte until the full access and output-enable delays have passed. A read window that is even one cycle short therefore shows up as a wrong byte, not as a timing warning. The model also measures setup, pulse, data-valid, recovery and driver turn-on/off spacing on every write, so each timing minimum fails on its own. A request pulsed during a busy read separates a correct handshake from one that starts or corrupts an access.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_STANDBY,
        ST_IDLE,
        ST_RD_WINDOW,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOV
    } ctrl_state_e;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic wstb_n;
        logic oen_n;
        logic drive;
    } mem_strobe_t;

    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned sat_sub(int unsigned a, int unsigned b);
        return (a > b) ? (a - b) : 0;
    endfunction

    function automatic mem_strobe_t strobes_for(ctrl_state_e st, logic drive);
        mem_strobe_t s;
        s.sel_n  = 1'b0;
        s.sel    = 1'b1;
        s.wstb_n = 1'b1;
        s.oen_n  = 1'b1;
        s.drive  = drive;
        unique case (st)
            ST_STANDBY: begin
                s.sel_n = 1'b1;
                s.sel   = 1'b0;
                s.drive = 1'b0;
            end
            ST_RD_WINDOW: begin
                s.oen_n = 1'b0;
                s.drive = 1'b0;
            end
            ST_WR_PULSE:  s.wstb_n = 1'b0;
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

    assert_timer_floor_R6: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_wdata,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (load_wdata) wdata_q <= wdata_in;
            if (capture)    rdata_q <= dq_in;
        end
    end

    assert_wdata_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !load_wdata |=> $stable(wdata_q));
endmodule

// File: rtl/sram_timing_ctrl.sv
module sram_timing_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 4,
    parameter int unsigned ADDR_W        = 13,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned RD_CYCLE_NS   = 500,
    parameter int unsigned RD_ACCESS_NS  = 500,
    parameter int unsigned OE_ACCESS_NS  = 200,
    parameter int unsigned WR_SETUP_NS   = 100,
    parameter int unsigned WR_PULSE_NS   = 150,
    parameter int unsigned WR_DATA_NS    = 100,
    parameter int unsigned WR_RECOV_NS   = 50,
    parameter int unsigned WR_CYCLE_NS   = 500,
    parameter int unsigned WR_SEL_NS     = 250,
    parameter int unsigned OE_FLOAT_NS   = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned P = CLK_PERIOD_NS;
    localparam int unsigned RD_CYC = max2(ns_to_cyc(RD_CYCLE_NS, P),
                                     max2(ns_to_cyc(RD_ACCESS_NS, P), ns_to_cyc(OE_ACCESS_NS, P)));
    localparam int unsigned WS_CYC = max2(ns_to_cyc(WR_SETUP_NS, P), ns_to_cyc(OE_FLOAT_NS, P));
    localparam int unsigned WP_CYC = max2(ns_to_cyc(WR_PULSE_NS, P),
                                     max2(ns_to_cyc(WR_DATA_NS, P),
                                          sat_sub(ns_to_cyc(WR_SEL_NS, P), WS_CYC)));
    localparam int unsigned WR_CYC = max2(ns_to_cyc(WR_RECOV_NS, P),
                                     sat_sub(ns_to_cyc(WR_CYCLE_NS, P), WS_CYC + WP_CYC));
    localparam int unsigned MAX_CYC = max2(max2(RD_CYC, WS_CYC), max2(WP_CYC, WR_CYC));
    localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);

    ctrl_state_e       state_q, state_n;
    mem_strobe_t       strobe_q, strobe_n;
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;
    logic              accept;
    logic              load;
    logic [CNT_W-1:0]  load_val;
    logic              last;
    logic              drive_n;
    logic              capture;

    assign req_ready = (state_q == ST_STANDBY) || (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;

    always_comb begin
        state_n  = state_q;
        load     = 1'b0;
        load_val = '0;
        unique case (state_q)
            ST_STANDBY, ST_IDLE: begin
                if (req_valid) begin
                    load = 1'b1;
                    if (req_write) begin
                        state_n  = ST_WR_SETUP;
                        load_val = CNT_W'(WS_CYC - 1);
                    end else begin
                        state_n  = ST_RD_WINDOW;
                        load_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_RD_WINDOW: if (last) state_n = ST_IDLE;
            ST_WR_SETUP: if (last) begin
                state_n  = ST_WR_PULSE;
                load     = 1'b1;
                load_val = CNT_W'(WP_CYC - 1);
            end
            ST_WR_PULSE: if (last) begin
                state_n  = ST_WR_RECOV;
                load     = 1'b1;
                load_val = CNT_W'(WR_CYC - 1);
            end
            ST_WR_RECOV: if (last) state_n = ST_IDLE;
            default: state_n = ST_STANDBY;
        endcase
    end

    assign drive_n  = (state_n == ST_WR_PULSE) ||
                      (state_q == ST_WR_PULSE && state_n == ST_WR_RECOV);
    assign strobe_n = strobes_for(state_n, drive_n);
    assign capture  = (state_q == ST_RD_WINDOW) && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_STANDBY;
            strobe_q <= strobes_for(ST_STANDBY, 1'b0);
            addr_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            state_q  <= state_n;
            strobe_q <= strobe_n;
            if (accept) addr_q <= req_addr;
            done_q   <= last && (state_q == ST_RD_WINDOW || state_q == ST_WR_RECOV);
        end
    end

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .last     (last)
    );

    sram_dq_path #(.DATA_W(DATA_W)) u_dq (
        .clk        (clk),
        .rst        (rst),
        .load_wdata (accept && req_write),
        .wdata_in   (req_wdata),
        .capture    (capture),
        .dq_in      (mem_dq_in),
        .wdata_q    (mem_dq_out),
        .rdata_q    (rsp_rdata)
    );

    assign mem_addr  = addr_q;
    assign mem_ce_n  = strobe_q.sel_n;
    assign mem_ce    = strobe_q.sel;
    assign mem_we_n  = strobe_q.wstb_n;
    assign mem_oe_n  = strobe_q.oen_n;
    assign mem_dq_oe = strobe_q.drive;
    assign rsp_done  = done_q;

    assert_reset_standby_R1: assert property (@(posedge clk)
        $past(rst) |-> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_ready_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> $stable(mem_addr));

    assert_no_contention_R7: assert property (@(posedge clk) disable iff (rst)
        !(mem_dq_oe && !mem_oe_n));

    assert_drive_in_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> !mem_we_n);

    assert_drive_off_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |=> !mem_dq_oe);
endmodule

// File: tb/sim_sram_timing_ctrl.sv
module sim_sram_timing_ctrl;
    localparam int P = 4;

    function automatic int cyc(int ns);
        return (ns + P - 1) / P;
    endfunction

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_done;
    logic [7:0]  rsp_rdata;
    logic [12:0] mem_addr;
    logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sram_timing_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // memory model with timing monitors, sampled away from the active edge
    logic [7:0]  sram    [0:8191];
    logic [7:0]  exp_mem [0:8191];
    logic [12:0] prev_addr = '0;
    logic [7:0]  prev_dout = '0;
    bit prev_we = 1, prev_drv = 0;
    int addr_cnt = 0, we_lo = 0, we_hi = 0, oe_hi = 0, oe_lo = 0, sel_cnt = 0;
    int dat_cnt = 0, since_rise = 0;
    bit last_wr = 0;

    always @(negedge clk) begin
        bit sel;
        if (rst) begin
            addr_cnt = 0; we_lo = 0; we_hi = 100; oe_hi = 100; oe_lo = 0;
            sel_cnt = 0; dat_cnt = 0; since_rise = 0;
            prev_we = 1; prev_drv = 0; mem_dq_in = 8'hEE;
        end else begin
            sel = !mem_ce_n && mem_ce;
            addr_cnt = (mem_addr != prev_addr) ? 1 : addr_cnt + 1;
            sel_cnt  = sel ? sel_cnt + 1 : 0;
            oe_hi    = mem_oe_n ? oe_hi + 1 : 0;
            we_hi    = mem_we_n ? we_hi + 1 : 0;
            since_rise = since_rise + 1;
            if (mem_dq_oe) dat_cnt = (prev_drv && mem_dq_out == prev_dout) ? dat_cnt + 1 : 1;
            else dat_cnt = 0;
            if (!mem_we_n && prev_we)   // falling write strobe
                chk(addr_cnt - 1 >= cyc(100) && sel_cnt - 1 >= cyc(100), "R4 setup", addr_cnt - 1, cyc(100));
            if (!mem_we_n) we_lo++;
            if (mem_we_n && !prev_we && sel) begin   // rising write strobe: memory latches
                chk(we_lo >= cyc(150), "R5 pulse", we_lo, cyc(150));
                chk(dat_cnt - 1 >= cyc(100), "R5 data valid", dat_cnt - 1, cyc(100));
                chk(addr_cnt - 1 >= cyc(250), "R5 addr to end", addr_cnt - 1, cyc(250));
                sram[mem_addr] = mem_dq_out;
                we_lo = 0;
                since_rise = 0;
            end
            if (mem_dq_oe) chk(!(sel && !mem_oe_n), "R7 contention", 1, 0);
            if (mem_dq_oe && !prev_drv) chk(oe_hi - 1 >= cyc(40), "R7 float", oe_hi - 1, cyc(40));
            if (!mem_dq_oe && prev_drv) chk(we_hi == 2, "R7 drive off", we_hi, 2);
            if (rsp_done && last_wr) chk(since_rise >= cyc(50), "R6 recovery", since_rise, cyc(50));
            if (sel && !mem_oe_n && mem_we_n) begin
                oe_lo++;
                mem_dq_in = (oe_lo >= cyc(200) && addr_cnt >= cyc(500) && sel_cnt >= cyc(500))
                            ? sram[mem_addr] : 8'hEE;
            end else begin
                oe_lo = 0;
                mem_dq_in = 8'hEE;
            end
            prev_we = mem_we_n; prev_drv = mem_dq_oe;
            prev_addr = mem_addr; prev_dout = mem_dq_out;
        end
    end

    task automatic access(input bit wr, input logic [12:0] a, input logic [7:0] d);
        int lat;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        last_wr = wr;
        chk(req_ready, "R2 ready idle", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, "R2 busy", int'(req_ready), 0);
        lat = 1;
        while (!rsp_done && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == cyc(500) + 1, "R6 latency", lat, cyc(500) + 1);
        if (wr) exp_mem[a] = d;
        else chk(rsp_rdata == exp_mem[a], "R9 readback", int'(rsp_rdata), int'(exp_mem[a]));
        @(negedge clk);
        chk(!rsp_done, "R3 done pulse", int'(rsp_done), 0);
        chk(!mem_ce_n && mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe, "R8 idle",
            {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b01110);
    endtask

    task automatic read_strobe_check(input logic [12:0] a);
        int lo;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; last_wr = 0;
        @(negedge clk);
        req_valid = 0;
        lo = 0;
        while (!mem_oe_n && !mem_ce_n && mem_ce && mem_we_n) begin
            lo++;
            @(negedge clk);
        end
        chk(lo == cyc(500), "R3 read window", lo, cyc(500));
        chk(rsp_done && rsp_rdata == exp_mem[a], "R3 data at done", int'(rsp_rdata), int'(exp_mem[a]));
    endtask

    task automatic busy_ignore(input logic [12:0] a, input logic [12:0] b);
        bit ok;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; last_wr = 0;
        @(negedge clk);
        req_valid = 0;
        repeat (20) @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = b; req_wdata = 8'h5A;
        ok = 1;
        repeat (5) begin
            @(negedge clk);
            if (req_ready || mem_addr != a || !mem_we_n || mem_oe_n) ok = 0;
        end
        req_valid = 0;
        chk(ok, "R10 busy request", int'(mem_addr), int'(a));
        while (!rsp_done) @(negedge clk);
        chk(rsp_rdata == exp_mem[a], "R10 read intact", int'(rsp_rdata), int'(exp_mem[a]));
        ok = 1;
        repeat (4) begin
            @(negedge clk);
            if (!mem_we_n || !mem_oe_n || !req_ready || mem_addr != a) ok = 0;
        end
        chk(ok, "R10 no extra access", int'(mem_addr), int'(a));
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        for (int i = 0; i < 8192; i++) begin
            sram[i] = 8'h00;
            exp_mem[i] = 8'h00;
        end
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_done && req_ready,
            "R1 in reset", {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
        rst = 0;
        @(negedge clk);
        chk(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_done && req_ready,
            "R1 after reset", {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);

        // directed corners
        access(1, 13'h0000, 8'h3C);       // first access leaves standby
        access(1, 13'h1FFF, 8'hC3);
        access(0, 13'h0000, 8'h00);
        access(0, 13'h1FFF, 8'h00);
        access(0, 13'h0ABC, 8'h00);       // never written
        access(1, 13'h0005, 8'h11);
        access(1, 13'h0005, 8'h22);       // overwrite
        access(0, 13'h0005, 8'h00);
        read_strobe_check(13'h1FFF);
        busy_ignore(13'h0005, 13'h0006);
        access(0, 13'h0006, 8'h00);

        // random mix in a narrow window
        for (int k = 0; k < 60; k++) begin
            logic [12:0] a;
            a = ($urandom % 4 == 0) ? 13'($urandom) : 13'($urandom % 16);
            access(1'($urandom), a, 8'($urandom));
        end
        repeat (3) @(negedge clk);
        summary();
    end
endmodule